// File: doc/BRIEF.md
# NaN Propagation Selector (binary32, two operands)

This block produces the NaN result of a two-input binary32 operation when at least one operand is already a NaN. It also raises an invalid-operation flag. A two-bit policy input picks one of three rules that decide which operand survives. The surviving operand is always made quiet before it leaves. A default-NaN mode bit replaces the result with one fixed canonical NaN. The invalid flag is still reported in that mode. The block does not decide whether propagation is needed and never produces non-NaN arithmetic results.

Each beat carries the operands together with the policy and mode bits on a valid/ready stream. With `REG_OUT = 0` the result path is purely combinational. `out_valid` follows `in_valid` in the same cycle, and `in_ready` is `out_ready`. With `REG_OUT = 1` (the default) one pipeline register sits on the output. A beat is taken when `in_valid && in_ready`. A presented result is held unchanged until `out_ready` is seen high. `in_ready` is high whenever the register is empty or is being drained in the same cycle, so a full-rate stream flows with one cycle of latency.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its 8 exponent bits [30:23] are all ones and its fraction [22:0] is nonzero. A NaN is quiet when fraction bit 22 is 1 and signaling when bit 22 is 0.
- R2: `out_invalid` is 1 exactly when at least one operand is a signaling NaN, including beats where default-NaN mode is set.
- R3: When `in_dflt_mode` is 1, the result is 0x7FC00000 whatever the operands and policy.
- R4: Policy 0 (and the spare code 3) takes the first match of: A signaling, B signaling, A quiet, otherwise B.
- R5: Policy 1 takes A when A is any NaN and B otherwise.
- R6: Policy 2 returns the quiet operand when one operand is signaling and the other quiet, and returns the NaN operand when only one operand is a NaN.
- R7: Under policy 2, when both operands are signaling or both are quiet, the operand with the larger magnitude bits [30:0] wins. When these bits are equal, A wins only if its full 32-bit encoding is numerically smaller than B's, so the positive one is chosen.
- R8: The result is the chosen operand with fraction bit 22 forced to 1 and all other bits unchanged.
- R9: When A is not a NaN, every policy selects B.
- R10: With `REG_OUT = 0` the result, flag and `out_valid` follow the inputs in the same cycle and `in_ready` equals `out_ready`. With `REG_OUT = 1` a result appears one cycle after acceptance and is held stable while `out_ready` is low. In that mode `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R11: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_a | input | 32 | First operand A |
| in_b | input | 32 | Second operand B |
| in_policy | input | 2 | Selection rule: 0 ordered, 1 first-NaN, 2 magnitude, 3 as 0 |
| in_dflt_mode | input | 1 | Force the canonical default NaN |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Propagated quiet NaN |
| out_invalid | output | 1 | Invalid-operation flag for the beat |

## Verification
Several properties are checked on every cycle: the forced quiet bit on every output beat, hold-while-stalled, the ready rule, the default-NaN substitution, the invalid flag for signaling inputs, and passing B whenever A is not a NaN. Which operand each policy picks, the significand comparison and its sign tie-break, and in-order delivery under an irregular `out_ready` pattern are shown only by the bench's scenarios. The bench compares every delivered beat against its own model. It also drives a combinational instance in the same cycles.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

  typedef enum logic [1:0] {
    POL_ORDERED     = 2'd0,
    POL_FIRST       = 2'd1,
    POL_MAGNITUDE   = 2'd2,
    POL_ORDERED_ALT = 2'd3
  } nan_policy_e;

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
  import nanprop_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] value,
  output nan_class_t   cls
);
  logic exp_ones;
  logic frac_nz;

  assign exp_ones = &value[W-2 -: EXP_W];
  assign frac_nz  = |value[MAN_W-1:0];

  always_comb begin
    cls.is_nan   = exp_ones & frac_nz;
    cls.is_quiet = exp_ones & frac_nz & value[MAN_W-1];
    cls.is_sig   = exp_ones & frac_nz & ~value[MAN_W-1];
  end
endmodule

// File: rtl/nanprop_magcmp.sv
module nanprop_magcmp #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         a_larger
);
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;

  assign mag_a = op_a[W-2:0];
  assign mag_b = op_b[W-2:0];

  always_comb begin
    if (mag_a != mag_b) a_larger = (mag_a > mag_b);
    else                a_larger = (op_a < op_b);
  end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
  import nanprop_pkg::*;
(
  input  nan_policy_e policy,
  input  nan_class_t  cls_a,
  input  nan_class_t  cls_b,
  input  logic        a_larger,
  output logic        sel_b
);
  always_comb begin
    unique case (policy)
      POL_FIRST: sel_b = ~cls_a.is_nan;
      POL_MAGNITUDE: begin
        if (cls_a.is_sig) begin
          if (cls_b.is_sig) sel_b = ~a_larger;
          else              sel_b = cls_b.is_quiet;
        end else if (cls_a.is_quiet) begin
          if (cls_b.is_sig || !cls_b.is_quiet) sel_b = 1'b0;
          else                                 sel_b = ~a_larger;
        end else begin
          sel_b = 1'b1;
        end
      end
      default: begin
        if      (cls_a.is_sig)   sel_b = 1'b0;
        else if (cls_b.is_sig)   sel_b = 1'b1;
        else if (cls_a.is_quiet) sel_b = 1'b0;
        else                     sel_b = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nanprop_emit.sv
module nanprop_emit #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sel_b,
  input  logic         dflt_mode,
  output logic [W-1:0] result
);
  localparam logic [W-1:0] QBIT    = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [W-1:0] chosen;

  assign chosen = sel_b ? op_b : op_a;
  assign result = dflt_mode ? DEF_NAN : (chosen | QBIT);
endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
  import nanprop_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int REG_OUT = 1,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [1:0]   in_policy,
  input  logic         in_dflt_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_invalid
);
  localparam int NOPS = 2;

  logic [W-1:0] ops [NOPS];
  nan_class_t   cls [NOPS];
  logic         a_larger;
  logic         sel_b;
  logic [W-1:0] nxt_result;
  logic         nxt_invalid;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    nanprop_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
      .value (ops[i]),
      .cls   (cls[i])
    );
  end

  nanprop_magcmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cmp_i (
    .op_a     (in_a),
    .op_b     (in_b),
    .a_larger (a_larger)
  );

  nanprop_pick pick_i (
    .policy   (nan_policy_e'(in_policy)),
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .a_larger (a_larger),
    .sel_b    (sel_b)
  );

  nanprop_emit #(.EXP_W(EXP_W), .MAN_W(MAN_W)) emit_i (
    .op_a      (in_a),
    .op_b      (in_b),
    .sel_b     (sel_b),
    .dflt_mode (in_dflt_mode),
    .result    (nxt_result)
  );

  assign nxt_invalid = cls[0].is_sig | cls[1].is_sig;

  if (REG_OUT != 0) begin : g_reg
    logic         vld_q;
    logic [W-1:0] res_q;
    logic         inv_q;

    assign in_ready = ~vld_q | out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
        inv_q <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          res_q <= nxt_result;
          inv_q <= nxt_invalid;
        end
      end
    end

    assign out_valid   = vld_q;
    assign out_result  = res_q;
    assign out_invalid = inv_q;
  end else begin : g_comb
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_result  = nxt_result;
    assign out_invalid = nxt_invalid;
  end
endmodule

// File: rtl/nanprop_sel_chk.sv
module nanprop_sel_chk #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter int REG_OUT = 1,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [1:0]   in_policy,
  input logic         in_dflt_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic         out_invalid
);
  localparam logic [W-1:0] QBIT    = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] DEF_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, a_sig, b_sig, any_sig, take;

  assign a_nan   = (&in_a[W-2 -: EXP_W]) && (|in_a[MAN_W-1:0]);
  assign a_sig   = a_nan && !in_a[MAN_W-1];
  assign b_sig   = (&in_b[W-2 -: EXP_W]) && (|in_b[MAN_W-1:0]) && !in_b[MAN_W-1];
  assign any_sig = a_sig || b_sig;
  assign take    = in_valid && in_ready;

  assert_quiet_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[MAN_W-1]);

  if (REG_OUT != 0) begin : g_reg_chk
    assert_reset_idle_R11: assert property (@(posedge clk)
      !rst_n |-> !out_valid);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_invalid));

    assert_ready_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    assert_default_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_dflt_mode |=> out_valid && out_result == DEF_NAN);

    assert_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take && any_sig |=> out_valid && out_invalid);

    assert_a_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      take && !a_nan && !in_dflt_mode |=> out_result == $past(in_b | QBIT));
  end else begin : g_comb_chk
    assert_ready_rule_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == out_ready && out_valid == in_valid);

    assert_default_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_dflt_mode |-> out_result == DEF_NAN);

    assert_invalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_invalid == any_sig);

    assert_a_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !a_nan && !in_dflt_mode |-> out_result == (in_b | QBIT));
  end
endmodule

bind nanprop_sel nanprop_sel_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .REG_OUT(REG_OUT)
) chk_i (.*);

// File: tb/nanprop_sel_tb_top.sv
module nanprop_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [1:0]  in_policy = '0;
  logic        in_dflt_mode = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid;

  logic        c_ready, c_valid, c_invalid;
  logic [31:0] c_result;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit stall_mode = 0;
  int cyc = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  nanprop_sel #(.REG_OUT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_policy(in_policy), .in_dflt_mode(in_dflt_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_invalid(out_invalid)
  );

  nanprop_sel #(.REG_OUT(0)) comb_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_ready),
    .in_a(in_a), .in_b(in_b), .in_policy(in_policy), .in_dflt_mode(in_dflt_mode),
    .out_valid(c_valid), .out_ready(1'b1), .out_result(c_result),
    .out_invalid(c_invalid)
  );

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] p, input logic dm);
    logic an, aq, as, bn, bq, bs, larger, selb, inv;
    logic [31:0] r;
    an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    aq = an && a[22];  as = an && !a[22];
    bq = bn && b[22];  bs = bn && !b[22];
    inv = as || bs;
    larger = (a[30:0] > b[30:0]) || ((a[30:0] == b[30:0]) && (a < b));
    case (p)
      2'd1: selb = !an;
      2'd2: begin
        if (as)      selb = bs ? !larger : bq;
        else if (aq) selb = (bq && !bs) ? !larger : 1'b0;
        else         selb = 1'b1;
      end
      default: selb = as ? 1'b0 : bs ? 1'b1 : aq ? 1'b0 : 1'b1;
    endcase
    r = dm ? 32'h7FC00000 : ((selb ? b : a) | 32'h0040_0000);
    return {inv, r};
  endfunction

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] p, input logic dm, input string tag);
    @(posedge clk); #2;
    in_a = a; in_b = b; in_policy = p; in_dflt_mode = dm; in_valid = 1'b1;
    exp_q.push_back(model(a, b, p, dm));
    tag_q.push_back(tag);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  // out_ready pattern driver
  initial begin
    forever begin
      @(posedge clk); #2;
      cyc++;
      out_ready = stall_mode ? (cyc[0] ^ cyc[2]) : 1'b1;
    end
  end

  // scoreboard monitor and per-cycle checks
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        total++;
        if (out_valid !== 1'b0) begin
          bad++;
          $display("FAIL R11 out_valid during reset act=%b exp=0", out_valid);
        end
      end else begin
        if (out_valid && out_ready) begin
          logic [32:0] e;
          string t;
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R10 unexpected beat act=%h exp=none", {out_invalid, out_result});
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_invalid, out_result} !== e) begin
              bad++;
              $display("FAIL %s act=%h exp=%h", t, {out_invalid, out_result}, e);
            end
          end
        end
        if (in_valid) begin
          logic [32:0] ce;
          ce = model(in_a, in_b, in_policy, in_dflt_mode);
          total++;
          if ({c_valid, c_ready, c_invalid, c_result} !== {2'b11, ce}) begin
            bad++;
            $display("FAIL R10 comb act=%h exp=%h", {c_valid, c_ready, c_invalid, c_result},
                     {2'b11, ce});
          end
          total++;
          if (in_ready !== (!out_valid || out_ready)) begin
            bad++;
            $display("FAIL R10 in_ready act=%b exp=%b", in_ready, (!out_valid || out_ready));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      report();
      $finish;
    end
  end

  task automatic run_set();
    send(32'h7FC00010, 32'h7F800020, 2'd0, 1'b0, "R4 p0 quietA sigB -> B");
    send(32'hFFC00ABC, 32'h7FC00001, 2'd0, 1'b0, "R4 p0 both quiet -> A");
    send(32'h7FC00010, 32'h7F800020, 2'd3, 1'b0, "R4 p3 like p0 -> B");
    send(32'h7FC00010, 32'h7F800020, 2'd1, 1'b0, "R5 p1 A nan -> A");
    send(32'h7F800040, 32'h7FC00002, 2'd1, 1'b0, "R5 R8 p1 sigA quieted");
    send(32'h7FC00010, 32'h7F800020, 2'd2, 1'b0, "R6 p2 quiet beats sig");
    send(32'h7F800007, 32'h3F800000, 2'd2, 1'b0, "R6 p2 single sigA");
    send(32'h7F800100, 32'hFF800200, 2'd2, 1'b0, "R7 p2 two sig larger B");
    send(32'h7FC00001, 32'hFFC00001, 2'd2, 1'b0, "R7 p2 tie positive A");
    send(32'hFFC00001, 32'h7FC00001, 2'd2, 1'b0, "R7 p2 tie positive B");
    send(32'h3F800000, 32'h7F800003, 2'd0, 1'b0, "R9 p0 A plain");
    send(32'h3F800000, 32'h7F800003, 2'd1, 1'b0, "R9 p1 A plain");
    send(32'h3F800000, 32'h7F800003, 2'd2, 1'b0, "R9 p2 A plain");
    send(32'h7F800005, 32'h7FC00000, 2'd2, 1'b1, "R2 R3 dflt with sig");
    send(32'h7FC12345, 32'hFFC00001, 2'd0, 1'b1, "R3 dflt quiet no inv");
    send(32'h7F800001, 32'h00000000, 2'd0, 1'b0, "R1 R8 min sig frac");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run_set();
    stall_mode = 1;
    run_set();
    for (int k = 0; k < 16; k++) send(32'h7F800000 | k, 32'h7FC00000 | (k << 1), 2'(k), 1'b0,
                                      "R4 R5 R6 stream");
    stall_mode = 0;
    while (exp_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      report();
      $finish;
    end
  end
endmodule